// File: doc/BRIEF.md
# Sign-Magnitude to Two's-Complement Q-Format Converter

This block takes a 64-bit sign-magnitude fixed-point word, with the sign in the top bit and a magnitude that carries 31 integer bits and 32 fraction bits. It turns that word into a signed two's-complement value in Qm.n form. Both m and n are fixed when the block is elaborated. m counts the sign bit, so the result occupies m+n significant bits. The result is sign-extended to a full 64-bit word.

Extra fraction bits are dropped by truncation. Values too large for the target format saturate. Saturation is asymmetric: positive values stop at the largest positive code, and negative values reach the most negative code.

The block has a plain pipelined interface with no backpressure. Each word is qualified by an input valid. The converted word appears one clock later, qualified by an output valid. A typical use is to convert colour-matrix coefficients from a software-friendly encoding into a hardware coefficient format. With the default Q3.12 the result spans [-4, 4 - 2^-12].

Top module: `sm2q_conv`

## Requirements
- R1: `out_valid` equals the `in_valid` value sampled at the previous rising clock edge (latency of one cycle).
- R2: For a positive input (bit 63 clear) whose aligned magnitude fits, the output equals the magnitude bits 62..0 shifted right by 32-FRAC_BITS, with dropped bits truncated and no rounding.
- R3: A positive input whose aligned magnitude exceeds 2^(INT_BITS+FRAC_BITS-1)-1 produces exactly that value.
- R4: A negative input (bit 63 set) whose aligned magnitude exceeds 2^(INT_BITS+FRAC_BITS-1) produces -2^(INT_BITS+FRAC_BITS-1), the most negative code.
- R5: A negative input within range produces the two's-complement negation of its aligned magnitude. All output bits from position INT_BITS+FRAC_BITS-1 up to 63 are equal, so the word is sign-extended.
- R6: A negative zero input (bit 63 set, bits 62..0 zero) produces an all-zero output.
- R7: While `in_valid` is low, `out_word` keeps its previous value.
- R8: A synchronous active-high `rst` clears `out_word` and `out_valid` to zero at the next rising edge, whatever the inputs are.
- R9: The parameters must satisfy INT_BITS <= 32, FRAC_BITS <= 32 and INT_BITS+FRAC_BITS >= 1, with INT_BITS = 0 allowed. Any other combination stops elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies `in_word` in this cycle |
| in_word | input | 64 | Sign-magnitude source: sign in bit 63, 31.32 magnitude in bits 62..0 |
| out_valid | output | 1 | Qualifies `out_word`, one cycle after `in_valid` |
| out_word | output | 64 | Sign-extended two's-complement Qm.n result |

## Verification
The bench builds the block with its defaults, INT_BITS = 3 and FRAC_BITS = 12, so the 15-bit result range is small enough to sweep completely. Every aligned magnitude from 0 up to just past the saturation points is applied with both signs. Junk bits below the truncation point go with each one. This reaches every in-range code, both saturation thresholds exactly at and one step beyond, and negative zero. Inputs with the top integer bits set exercise saturation far from the boundary. Idle cycles and a reset asserted in the middle of traffic cover the hold and clear behaviour.

// File: rtl/sm2q_pkg.sv
package sm2q_pkg;

    localparam int WORD_W   = 64;
    localparam int SRC_FRAC = 32;

    // magnitude travelling with its sign through the datapath
    typedef struct packed {
        logic              neg;
        logic [WORD_W-1:0] mag;
    } sm2q_mag_t;

    // largest magnitude allowed for a given sign and total width
    function automatic logic [WORD_W-1:0] sm2q_limit(input logic neg, input int total_w);
        logic [WORD_W-1:0] top_bit;
        top_bit = 64'd1 << (total_w - 1);
        return neg ? top_bit : (top_bit - 64'd1);
    endfunction

    // two's-complement application of the sign
    function automatic logic [WORD_W-1:0] sm2q_apply_sign(input sm2q_mag_t v);
        return v.neg ? (~v.mag + 64'd1) : v.mag;
    endfunction

endpackage

// File: rtl/sm2q_align.sv
module sm2q_align
    import sm2q_pkg::*;
#(
    parameter int FRAC_BITS = 12
) (
    input  logic [WORD_W-1:0] in_word,
    output sm2q_mag_t         aligned
);
    localparam int SHIFT = SRC_FRAC - FRAC_BITS;

    always_comb begin
        aligned.neg = in_word[WORD_W-1];
        aligned.mag = {1'b0, in_word[WORD_W-2:0]} >> SHIFT;
    end
endmodule

// File: rtl/sm2q_sat.sv
module sm2q_sat
    import sm2q_pkg::*;
#(
    parameter int TOTAL_W = 15
) (
    input  sm2q_mag_t raw,
    output sm2q_mag_t clamped
);
    localparam logic [WORD_W-1:0] LIM_POS = sm2q_limit(1'b0, TOTAL_W);
    localparam logic [WORD_W-1:0] LIM_NEG = sm2q_limit(1'b1, TOTAL_W);

    logic [WORD_W-1:0] limit;

    always_comb begin
        limit       = raw.neg ? LIM_NEG : LIM_POS;
        clamped.neg = raw.neg;
        clamped.mag = (raw.mag > limit) ? limit : raw.mag;
    end
endmodule

// File: rtl/sm2q_sign.sv
module sm2q_sign
    import sm2q_pkg::*;
(
    input  sm2q_mag_t         clamped,
    output logic [WORD_W-1:0] result
);
    always_comb begin
        result = sm2q_apply_sign(clamped);
    end
endmodule

// File: rtl/sm2q_conv.sv
module sm2q_conv
    import sm2q_pkg::*;
#(
    parameter int INT_BITS  = 3,
    parameter int FRAC_BITS = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word
);
    localparam int TOTAL_W = INT_BITS + FRAC_BITS;

    // R9: configuration guard at elaboration
    if (INT_BITS < 0 || INT_BITS > 32 || FRAC_BITS < 0 || FRAC_BITS > 32 || TOTAL_W < 1) begin : g_bad_cfg
        $error("sm2q_conv: INT_BITS and FRAC_BITS must be 0..32 with a sum of at least 1");
    end

    sm2q_mag_t         aligned;
    sm2q_mag_t         clamped;
    logic [WORD_W-1:0] result;

    sm2q_align #(.FRAC_BITS(FRAC_BITS)) align_i (
        .in_word (in_word),
        .aligned (aligned)
    );

    sm2q_sat #(.TOTAL_W(TOTAL_W)) sat_i (
        .raw     (aligned),
        .clamped (clamped)
    );

    sm2q_sign sign_i (
        .clamped (clamped),
        .result  (result)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_word <= result;
            end
        end
    end
endmodule

// File: rtl/sm2q_conv_chk.sv
module sm2q_conv_chk #(
    parameter int INT_BITS  = 3,
    parameter int FRAC_BITS = 12
) (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [63:0] in_word,
    input logic        out_valid,
    input logic [63:0] out_word
);
    localparam int TW = INT_BITS + FRAC_BITS;

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R1
    idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R3
    pos_nonneg_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_word[63]) |=> !out_word[63]);

    // R4
    neg_nonpos_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_word[63]) |=> (out_word[63] || out_word == 64'd0));

    // R5
    sign_ext_chk: assert property (@(posedge clk) disable iff (rst)
        ((&out_word[63:TW-1]) || !(|out_word[63:TW-1])));

    // R6
    neg_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_word == {1'b1, 63'd0}) |=> (out_word == 64'd0));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_word));
endmodule

bind sm2q_conv sm2q_conv_chk #(.INT_BITS(INT_BITS), .FRAC_BITS(FRAC_BITS)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .out_valid (out_valid),
    .out_word  (out_word)
);

// File: tb/sm2q_conv_tb_top.sv
module sm2q_conv_tb_top;
    localparam int M      = 3;
    localparam int N      = 12;
    localparam int TW     = M + N;
    localparam int SHIFT  = 32 - N;
    localparam longint POS_MAX = (64'd1 << (TW - 1)) - 1;
    localparam longint NEG_MAX = (64'd1 << (TW - 1));

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] in_word = '0;
    logic        out_valid;
    logic [63:0] out_word;

    int n_cmp = 0;
    int n_bad = 0;
    logic [63:0] last_exp = '0;

    always #5 clk = ~clk;

    sm2q_conv #(.INT_BITS(M), .FRAC_BITS(N)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .out_valid (out_valid),
        .out_word  (out_word)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one word, then compare one cycle later (R1 and data)
    task automatic push(input logic [63:0] w, input logic [63:0] exp, input string req);
        in_word  = w;
        in_valid = 1'b1;
        @(negedge clk);
        check(out_valid === 1'b1, "R1", {63'd0, out_valid}, 64'd1);
        check(out_word === exp, req, out_word, exp);
        last_exp = exp;
    endtask

    task automatic sweep_one(input longint k, input bit s, input logic [62:0] junk);
        logic [62:0] mag;
        longint      e;
        string       req;
        mag = (63'(k) << SHIFT) | (junk & ((63'd1 << SHIFT) - 63'd1));
        if (!s) begin
            e   = (k > POS_MAX) ? POS_MAX : k;
            req = (k > POS_MAX) ? "R3" : "R2";
            push({1'b0, mag}, 64'(e), req);
        end else begin
            e   = (k > NEG_MAX) ? NEG_MAX : k;
            req = (k == 0) ? "R6" : ((k > NEG_MAX) ? "R4" : "R5");
            push({1'b1, mag}, 64'd0 - 64'(e), req);
        end
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R8: reset clears outputs even with valid traffic presented
        in_valid = 1'b1;
        in_word  = 64'h0000_0001_0000_0000;
        @(negedge clk);
        @(negedge clk);
        check(out_valid === 1'b0, "R8", {63'd0, out_valid}, 64'd0);
        check(out_word === 64'd0, "R8", out_word, 64'd0);
        rst      = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        check(out_valid === 1'b0, "R1", {63'd0, out_valid}, 64'd0);

        // R2 R3 R4 R5 R6: full sweep of aligned magnitudes, both signs
        for (int k = 0; k <= NEG_MAX + 20; k++) begin
            for (int s = 0; s < 2; s++) begin
                sweep_one(longint'(k), s[0], 63'(k * 37 + s * 911));
            end
        end

        // R3 R4: far out of range, top integer bits set
        push({1'b0, 63'h7FFF_FFFF_FFFF_FFFF}, 64'(POS_MAX), "R3");
        push({1'b1, 63'h7FFF_FFFF_FFFF_FFFF}, 64'd0 - 64'(NEG_MAX), "R4");
        push({1'b0, 63'h4000_0000_0000_0000}, 64'(POS_MAX), "R3");
        push({1'b1, 63'h0000_0001_0000_0000 << 10}, 64'd0 - 64'(NEG_MAX), "R4");

        // R2: truncation, fraction bits below the cut discarded
        push({1'b0, 63'h0000_0000_000F_FFFF}, 64'd0, "R2");
        push({1'b1, 63'h0000_0000_000F_FFFF}, 64'd0, "R6");
        push({1'b1, 63'd0}, 64'd0, "R6");
        push({1'b1, 63'h0000_0000_0010_0000}, 64'hFFFF_FFFF_FFFF_FFFF, "R5");

        // R7: idle cycles hold data, valid drops (R1)
        for (int i = 0; i < 4; i++) begin
            in_valid = 1'b0;
            in_word  = {1'b0, 63'(i * 12345 + 99) << SHIFT};
            @(negedge clk);
            check(out_valid === 1'b0, "R1", {63'd0, out_valid}, 64'd0);
            check(out_word === last_exp, "R7", out_word, last_exp);
        end

        // R8: reset in the middle of traffic
        push({1'b0, 63'd777 << SHIFT}, 64'd777, "R2");
        rst      = 1'b1;
        in_valid = 1'b1;
        in_word  = {1'b1, 63'd5 << SHIFT};
        @(negedge clk);
        check(out_valid === 1'b0, "R8", {63'd0, out_valid}, 64'd0);
        check(out_word === 64'd0, "R8", out_word, 64'd0);
        rst = 1'b0;
        push({1'b1, 63'd5 << SHIFT}, 64'd0 - 64'd5, "R5");

        in_valid = 1'b0;
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule